// File: doc/BRIEF.md
# EEPROM Transaction Sequencer with Page and Block Wraparound

This block runs the transaction layer of a two-wire serial EEPROM slave. A byte-level front end hands it decoded bus events: start, repeated start, stop, a received byte, a request for a byte to transmit, and the master's not-acknowledge at the end of a read. For each received byte the sequencer returns an acknowledge decision one cycle later. It decodes the device address byte and keeps a 10-bit word address. It collects up to one page of 16 write bytes, and after a stop it commits them to a behavioural 1024-byte array. It then holds a busy period of `BUSY_CYC` clock cycles.

Protection decisions are made outside. The sequencer shows the address in use on `chk_addr`, and on `chk_wr` whether a write is being asked for. It then obeys `permit_in`. The write-protect input `wp_in` blocks every data commit, but commands that only set the address are still accepted.

States: `ST_IDLE` (wait for start), `ST_DEV` (device address byte), `ST_WADDR` (word address byte), `ST_WDATA` (collect data bytes), `ST_DROP` (refused or overflowed write; everything is refused until the next framing event), `ST_READ` (stream bytes out), `ST_COMMIT` (write buffer to array), `ST_BUSY` (program timer). Transitions:
- A start or repeated start moves any state except `ST_COMMIT`/`ST_BUSY` to `ST_DEV`.
- `ST_DEV` moves to `ST_WADDR` on a valid write code. It moves to `ST_READ` on a valid, permitted read code, and to `ST_IDLE` otherwise.
- `ST_WADDR` moves to `ST_WDATA` on the word address byte.
- `ST_WDATA` moves to `ST_DROP` on a refused or 17th byte.
- A stop moves `ST_WDATA` with buffered data and `wp_in` low to `ST_COMMIT`. A stop moves every other state to `ST_IDLE`.
- `ST_READ` moves to `ST_IDLE` on the master's not-acknowledge.
- `ST_COMMIT` always moves to `ST_BUSY`.
- `ST_BUSY` moves to `ST_IDLE` when its timer runs out.

Top module: `eeprom_txn_seq`

## Requirements
- R1: A device address byte whose upper five bits are 10101b (A8h to AFh) is acknowledged. Any other device address byte gets `ack_ok`=0, and the sequencer waits for a new start.
- R2: Bit 0 of the device address selects read (1) or write (0). On a write, bits 2:1 become the upper two bits of the word address, and the next byte supplies the lower eight bits.
- R3: During a write only address bits 3:0 advance after each accepted data byte, so bytes wrap to the start of the same 16-byte page.
- R4: A 17th data byte in one write gets `ack_ok`=0, the whole transfer is discarded, and no busy period follows.
- R5: During a read only address bits 6:0 advance after each byte sent, so the address wraps from 127 to 0 inside the current 128-byte block.
- R6: On a read, bits 2:1 of the device address are ignored, and the address left by the last write command is used.
- R7: Programming happens only after a stop. `busy` is then high for exactly `BUSY_CYC` cycles, and every byte received while `busy` is high, including in its last cycle, gets `ack_ok`=0.
- R8: A write that sends only the word address and then a stop or repeated start sets the read address, programs nothing and starts no busy period.
- R9: While `wp_in` is high, data bytes get `ack_ok`=0 and nothing is committed. Device and word address bytes are still acknowledged.
- R10: When `permit_in` is low, a write data byte gets `ack_ok`=0 and the transfer is discarded, and a read device address gets `ack_ok`=0.
- R11: A master not-acknowledge ends the read stream, and later byte requests give no `tx_vld`.
- R12: After reset `busy`, `ack_vld` and `tx_vld` are low, the word address is 0 and every array byte reads FFh.
- R13: `ack_vld` pulses exactly in the cycle after each `ev_byte_rx`. `tx_vld` pulses in the cycle after a byte request in a read, with `tx_byte` holding the array byte at the address current when the request arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_rstart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_byte_rx | input | 1 | A byte has been received from the master |
| rx_byte | input | 8 | The received byte, valid with `ev_byte_rx` |
| ev_byte_req | input | 1 | Front end needs the next byte to transmit |
| ev_mst_nack | input | 1 | Master did not acknowledge the last byte sent |
| wp_in | input | 1 | Write protect, active high |
| permit_in | input | 1 | Protection checker permits the access on `chk_addr`/`chk_wr` |
| chk_addr | output | 10 | Word address presented to the protection checker |
| chk_wr | output | 1 | The pending access is a data write |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_vld | output | 1 | `tx_byte` holds a fresh byte to send |
| tx_byte | output | 8 | Byte to transmit |
| busy | output | 1 | Program cycle in progress |

## Verification
Two functions meet in one cycle at the end of a program cycle. The busy timer expires, and a device address byte can arrive in that same cycle. The bench counts the exact number of `busy` cycles after a stop and delivers a device address byte so that it is sampled on the last busy edge. It expects that byte to be refused. An identical byte one cycle later, after a start, must be acknowledged. A second overlap is a data byte arriving when the page counter is already full. That byte must be refused, and the stop that follows must start no program cycle.

// File: rtl/eeprom_seq_pkg.sv
`timescale 1ns/1ps
package eeprom_seq_pkg;
    localparam int unsigned WORD_AW = 10;
    localparam int unsigned PAGE_AW = 4;
    localparam int unsigned BLK_AW  = 7;
    localparam int unsigned DATA_W  = 8;
    localparam logic [4:0]  DEV_TAG = 5'b10101;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_DROP, ST_READ, ST_COMMIT, ST_BUSY
    } seq_state_e;
endpackage

// File: rtl/seq_addr_reg.sv
`timescale 1ns/1ps
module seq_addr_reg #(
    parameter int unsigned AW = 10,
    parameter int unsigned PW = 4,
    parameter int unsigned BW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_pg,
    input  logic          step_blk,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step_pg) begin
            addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
        end else if (step_blk) begin
            addr_q[BW-1:0] <= addr_q[BW-1:0] + 1'b1;
        end
    end

    assign addr_o = addr_q;

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pg && !load) |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]))) else $error("page wrap"); // R3
    AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_blk && !step_pg && !load) |=> (addr_q[AW-1:BW] == $past(addr_q[AW-1:BW]))) else $error("block wrap"); // R5
endmodule

// File: rtl/seq_page_buf.sv
`timescale 1ns/1ps
module seq_page_buf #(
    parameter int unsigned PW = 4,
    parameter int unsigned DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [PW-1:0]           idx,
    input  logic [DW-1:0]           din,
    output logic [(2**PW)*DW-1:0]   data_o,
    output logic [2**PW-1:0]        mask_o
);
    localparam int unsigned SLOTS = 2**PW;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[s]             <= 1'b0;
                data_o[s*DW +: DW]    <= '0;
            end else if (clr) begin
                mask_o[s]             <= 1'b0;
            end else if (wr && (idx == PW'(s))) begin
                mask_o[s]             <= 1'b1;
                data_o[s*DW +: DW]    <= din;
            end
        end
    end
endmodule

// File: rtl/seq_store.sv
`timescale 1ns/1ps
module seq_store #(
    parameter int unsigned AW = 10,
    parameter int unsigned PW = 4,
    parameter int unsigned DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [AW-PW-1:0]        page,
    input  logic [(2**PW)*DW-1:0]   buf_data,
    input  logic [2**PW-1:0]        buf_mask,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data
);
    localparam int unsigned DEPTH = 2**AW;
    localparam int unsigned SLOTS = 2**PW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (buf_mask[s]) cells[{page, PW'(s)}] <= buf_data[s*DW +: DW];
            end
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_txn_seq.sv
`timescale 1ns/1ps
module eeprom_txn_seq
    import eeprom_seq_pkg::*;
#(
    parameter int unsigned AW       = WORD_AW,
    parameter int unsigned PW       = PAGE_AW,
    parameter int unsigned BW       = BLK_AW,
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned BUSY_CYC = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_rstart,
    input  logic          ev_stop,
    input  logic          ev_byte_rx,
    input  logic [DW-1:0] rx_byte,
    input  logic          ev_byte_req,
    input  logic          ev_mst_nack,
    input  logic          wp_in,
    input  logic          permit_in,
    output logic [AW-1:0] chk_addr,
    output logic          chk_wr,
    output logic          ack_vld,
    output logic          ack_ok,
    output logic          tx_vld,
    output logic [DW-1:0] tx_byte,
    output logic          busy
);
    localparam int unsigned HI_W   = AW - DW;
    localparam int unsigned PAGE_N = 2**PW;
    localparam int unsigned CNT_W  = PW + 1;
    localparam int unsigned TMR_W  = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

    seq_state_e       st_q, st_d;
    logic [HI_W-1:0]  hi_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TMR_W-1:0] tmr_q;

    logic             ack_set, ack_val, ld, step_pg, step_blk;
    logic             buf_clr, buf_wr, cnt_inc, hi_ld, tx_set, commit;
    logic             tmr_ld, tmr_dec, framing;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    rd_data;
    logic [PAGE_N*DW-1:0] buf_data;
    logic [PAGE_N-1:0]    buf_mask;

    // next state and per-cycle actions
    always_comb begin
        st_d     = st_q;
        ack_set  = 1'b0;  ack_val  = 1'b0;
        ld       = 1'b0;  step_pg  = 1'b0;  step_blk = 1'b0;
        buf_clr  = 1'b0;  buf_wr   = 1'b0;  cnt_inc  = 1'b0;
        hi_ld    = 1'b0;  tx_set   = 1'b0;  commit   = 1'b0;
        tmr_ld   = 1'b0;  tmr_dec  = 1'b0;
        framing  = (st_q != ST_COMMIT) && (st_q != ST_BUSY);
        if (ev_byte_rx) ack_set = 1'b1;
        unique case (st_q)
            ST_IDLE: ;
            ST_DEV: begin
                if (ev_byte_rx) begin
                    st_d = ST_IDLE;
                    if (rx_byte[7:3] == DEV_TAG) begin
                        if (!rx_byte[0]) begin
                            ack_val = 1'b1;
                            hi_ld   = 1'b1;
                            st_d    = ST_WADDR;
                        end else if (permit_in) begin
                            ack_val = 1'b1;
                            st_d    = ST_READ;
                        end
                    end
                end
            end
            ST_WADDR: begin
                if (ev_byte_rx) begin
                    ack_val = 1'b1;
                    ld      = 1'b1;
                    st_d    = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (ev_byte_rx) begin
                    if ((cnt_q == CNT_W'(PAGE_N)) || wp_in || !permit_in) begin
                        st_d = ST_DROP;
                    end else begin
                        ack_val = 1'b1;
                        buf_wr  = 1'b1;
                        step_pg = 1'b1;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_DROP: ;
            ST_READ: begin
                if (ev_byte_req) begin
                    tx_set   = 1'b1;
                    step_blk = 1'b1;
                end
                if (ev_mst_nack) st_d = ST_IDLE;
            end
            ST_COMMIT: begin
                commit = 1'b1;
                tmr_ld = 1'b1;
                st_d   = ST_BUSY;
            end
            ST_BUSY: begin
                if (tmr_q == '0) st_d = ST_IDLE;
                else             tmr_dec = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
        if (framing) begin
            if (ev_start || ev_rstart) begin
                st_d    = ST_DEV;
                buf_clr = 1'b1;
            end else if (ev_stop) begin
                if ((st_q == ST_WDATA) && (cnt_q != '0) && !wp_in) st_d = ST_COMMIT;
                else                                                 st_d = ST_IDLE;
            end
        end
    end

    // state register and its companion counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            hi_q  <= '0;
            cnt_q <= '0;
            tmr_q <= '0;
        end else begin
            st_q <= st_d;
            if (hi_ld)        hi_q  <= rx_byte[HI_W:1];
            if (ld || buf_clr) cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
            if (tmr_ld)       tmr_q <= TMR_W'(BUSY_CYC - 1);
            else if (tmr_dec) tmr_q <= tmr_q - 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
            tx_vld  <= 1'b0;
            tx_byte <= '0;
        end else begin
            ack_vld <= ack_set;
            ack_ok  <= ack_set && ack_val;
            tx_vld  <= tx_set;
            if (tx_set) tx_byte <= rd_data;
        end
    end

    assign busy     = (st_q == ST_BUSY);
    assign chk_addr = addr;
    assign chk_wr   = (st_q == ST_WDATA);

    seq_addr_reg #(.AW(AW), .PW(PW), .BW(BW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val({hi_q, rx_byte}),
        .step_pg(step_pg), .step_blk(step_blk), .addr_o(addr)
    );

    seq_page_buf #(.PW(PW), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr || ld), .wr(buf_wr),
        .idx(addr[PW-1:0]), .din(rx_byte), .data_o(buf_data), .mask_o(buf_mask)
    );

    seq_store #(.AW(AW), .PW(PW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(addr[AW-1:PW]),
        .buf_data(buf_data), .buf_mask(buf_mask), .rd_addr(addr), .rd_data(rd_data)
    );

    AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_rx |=> ack_vld) else $error("ack missing"); // R13
    AST_ACK_ONLY_FOR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_byte_rx |=> !ack_vld) else $error("stray ack"); // R13
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_byte_rx) |=> !ack_ok) else $error("ack while busy"); // R7
    AST_OVERFLOW_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WDATA && ev_byte_rx && cnt_q == CNT_W'(PAGE_N)) |=> !ack_ok) else $error("17th acked"); // R4
    AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMMIT) |-> $past(!wp_in)) else $error("commit under wp"); // R9
    AST_READ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && ev_byte_req) |=> !tx_vld) else $error("tx after end"); // R11
endmodule

// File: tb/sim_eeprom_txn_seq.sv
`timescale 1ns/1ps
module sim_eeprom_txn_seq;
    localparam int unsigned BUSY_CYC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_byte_rx = 0;
    logic ev_byte_req = 0, ev_mst_nack = 0, wp_in = 0, permit_in = 1;
    logic [7:0] rx_byte = '0;
    logic [9:0] chk_addr;
    logic chk_wr, ack_vld, ack_ok, tx_vld, busy;
    logic [7:0] tx_byte;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_mem [1024];

    always #2.5 clk = ~clk;

    eeprom_txn_seq #(.BUSY_CYC(BUSY_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
        .ev_stop(ev_stop), .ev_byte_rx(ev_byte_rx), .rx_byte(rx_byte),
        .ev_byte_req(ev_byte_req), .ev_mst_nack(ev_mst_nack), .wp_in(wp_in),
        .permit_in(permit_in), .chk_addr(chk_addr), .chk_wr(chk_wr),
        .ack_vld(ack_vld), .ack_ok(ack_ok), .tx_vld(tx_vld), .tx_byte(tx_byte),
        .busy(busy)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic do_start();  ev_start = 1;  @(negedge clk); ev_start = 0;  endtask
    task automatic do_rstart(); ev_rstart = 1; @(negedge clk); ev_rstart = 0; endtask
    task automatic do_stop();   ev_stop = 1;   @(negedge clk); ev_stop = 0;   endtask
    task automatic do_mnack();  ev_mst_nack = 1; @(negedge clk); ev_mst_nack = 0; endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        ev_byte_rx = 1; rx_byte = b;
        @(negedge clk);
        ev_byte_rx = 0;
        chk_eq("R13", "ack_vld", int'(ack_vld), 1);
        ack = ack_ok;
    endtask

    task automatic read_byte(output logic [7:0] d, output logic v);
        ev_byte_req = 1;
        @(negedge clk);
        ev_byte_req = 0;
        v = tx_vld; d = tx_byte;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic set_addr(input logic [7:0] dev, input logic [7:0] w, input string req);
        logic a;
        do_start();
        send_byte(dev, a); chk_eq(req, "dev ack", int'(a), 1);
        send_byte(w, a);   chk_eq(req, "word ack", int'(a), 1);
    endtask

    task automatic read_check(input logic [7:0] dev, input logic [9:0] start_a, input int n, input string req);
        logic a, v;
        logic [7:0] d;
        do_start();
        send_byte(dev, a); chk_eq(req, "read dev ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            logic [9:0] ea;
            ea = {start_a[9:7], 7'(start_a[6:0] + 7'(i))};
            read_byte(d, v);
            chk_eq("R13", "tx_vld", int'(v), 1);
            chk_eq(req, $sformatf("byte @%0h", ea), int'(d), int'(exp_mem[ea]));
        end
        do_mnack();
        do_stop();
    endtask

    task automatic t_reset();
        chk_eq("R12", "busy", int'(busy), 0);
        chk_eq("R12", "ack_vld", int'(ack_vld), 0);
        chk_eq("R12", "tx_vld", int'(tx_vld), 0);
        read_check(8'hA9, 10'h000, 2, "R12");
    endtask

    task automatic t_bad_dev();
        logic a;
        do_start(); send_byte(8'hA0, a); chk_eq("R1", "A0 nack", int'(a), 0);
        do_start(); send_byte(8'hB8, a); chk_eq("R1", "B8 nack", int'(a), 0);
        send_byte(8'h00, a); chk_eq("R1", "byte after refused dev", int'(a), 0);
        do_stop();
    endtask

    // page write near the page end at address 21Eh, then read back the page
    task automatic t_page_wrap();
        logic a;
        logic [7:0] vals [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        set_addr(8'hAC, 8'h1E, "R2");
        for (int i = 0; i < 4; i++) begin
            send_byte(vals[i], a); chk_eq("R3", "data ack", int'(a), 1);
            exp_mem[{6'h21, 4'(4'hE + 4'(i))}] = vals[i];
        end
        chk_eq("R7", "busy before stop", int'(busy), 0);
        do_stop();
        @(negedge clk);
        chk_eq("R7", "busy after stop", int'(busy), 1);
        wait_done();
        set_addr(8'hA8 | 8'h04, 8'h10, "R8");
        do_rstart();
        read_check(8'hA9, 10'h210, 16, "R3");
    endtask

    task automatic t_busy_edge();
        logic a;
        set_addr(8'hA8, 8'h00, "R2");
        send_byte(8'hC3, a); chk_eq("R7", "data ack", int'(a), 1);
        exp_mem[10'h000] = 8'hC3;
        do_stop();
        while (!busy) @(negedge clk);
        repeat (BUSY_CYC - 1) @(negedge clk);
        chk_eq("R7", "busy in last cycle", int'(busy), 1);
        send_byte(8'hA8, a);
        chk_eq("R7", "nack on last busy edge", int'(a), 0);
        chk_eq("R7", "busy ended", int'(busy), 0);
        do_start();
        send_byte(8'hA8, a); chk_eq("R7", "ack after busy", int'(a), 1);
        send_byte(8'h7F, a); chk_eq("R8", "word ack", int'(a), 1);
        do_stop();
        repeat (3) begin
            @(negedge clk);
            chk_eq("R8", "no busy after address-only write", int'(busy), 0);
        end
    endtask

    task automatic t_overflow();
        logic a;
        set_addr(8'hA8, 8'h40, "R2");
        for (int i = 0; i < 16; i++) begin
            send_byte(8'(i), a); chk_eq("R4", "byte within page acked", int'(a), 1);
        end
        send_byte(8'hEE, a); chk_eq("R4", "17th nack", int'(a), 0);
        do_stop();
        repeat (3) begin
            @(negedge clk);
            chk_eq("R4", "no busy", int'(busy), 0);
        end
        set_addr(8'hA8, 8'h40, "R4");
        do_stop();
        read_check(8'hA9, 10'h040, 16, "R4");
    endtask

    task automatic t_read_wrap();
        logic a;
        set_addr(8'hA8, 8'h7F, "R2");
        send_byte(8'h5A, a); chk_eq("R5", "data ack", int'(a), 1);
        exp_mem[10'h07F] = 8'h5A;
        do_stop();
        wait_done();
        set_addr(8'hA8, 8'h7F, "R6");
        do_rstart();
        // AFh carries block bits 11b, which must be ignored
        read_check(8'hAF, 10'h07F, 2, "R5");
    endtask

    task automatic t_wp();
        logic a;
        wp_in = 1;
        set_addr(8'hA8, 8'h90, "R9");
        send_byte(8'h77, a); chk_eq("R9", "data nack under wp", int'(a), 0);
        do_stop();
        repeat (2) begin
            @(negedge clk);
            chk_eq("R9", "no busy", int'(busy), 0);
        end
        set_addr(8'hA8, 8'h7F, "R9");
        do_stop();
        wp_in = 0;
        read_check(8'hA9, 10'h07F, 1, "R9");
        set_addr(8'hA8, 8'h90, "R9");
        do_stop();
        read_check(8'hA9, 10'h090, 1, "R9");
    endtask

    task automatic t_permit();
        logic a;
        permit_in = 0;
        set_addr(8'hA8, 8'h30, "R10");
        chk_eq("R10", "chk_addr", int'(chk_addr), 'h030);
        chk_eq("R10", "chk_wr", int'(chk_wr), 1);
        send_byte(8'h99, a); chk_eq("R10", "write data nack", int'(a), 0);
        do_stop();
        @(negedge clk);
        chk_eq("R10", "no busy", int'(busy), 0);
        do_start();
        send_byte(8'hA9, a); chk_eq("R10", "read dev nack", int'(a), 0);
        do_stop();
        permit_in = 1;
        set_addr(8'hA8, 8'h30, "R10");
        do_stop();
        read_check(8'hA9, 10'h030, 1, "R10");
    endtask

    task automatic t_mnack();
        logic a, v;
        logic [7:0] d;
        set_addr(8'hA8, 8'h00, "R2");
        do_rstart();
        send_byte(8'hA9, a); chk_eq("R11", "read dev ack", int'(a), 1);
        read_byte(d, v);
        chk_eq("R11", "first byte", int'(d), int'(exp_mem[10'h000]));
        do_mnack();
        read_byte(d, v);
        chk_eq("R11", "no tx after master nack", int'(v), 0);
        do_stop();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bad_dev();
        t_page_wrap();
        t_busy_edge();
        t_overflow();
        t_read_wrap();
        t_wp();
        t_permit();
        t_mnack();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule